// File: doc/BRIEF.md
# Banked Shadow Register File

This block is the general-purpose register storage of a pipelined core, built as several complete register banks ("shadow sets"). At any time one set is current: the two pipeline read ports and the pipeline write port address only that set. A small control register holds the current set number and a previous set number, which records the set that was current before the most recent entry into a handler.

On an interrupt entry the control register copies the current number into the previous field and loads a new current set taken from a per-level map, so that each interrupt priority level gets its own bank and needs no register save. An exception entry records the previous set but stays in the same bank. A return restores the previous set as current. Two cross-bank ports, one read and one write, always address the previous set. A handler uses them to fetch the interrupted code's stack pointer on entry and to write it back before returning.

All register ports are single-cycle commands that take effect at the next rising edge. Reads are combinational and include a same-cycle bypass from either write port. Choosing the interrupt level and forwarding between pipeline stages are done outside the block.

Top module: `shadow_regfile`

## Requirements
- R1: After reset, `cur_set` and `prv_set` are 0, and every register of every set reads as zero.
- R2: `rd_a_data` and `rd_b_data` return the registers selected by `rd_a_idx` and `rd_b_idx` in the current set. A pipeline write with `wr_en` high updates register `wr_idx` of the current set at the next edge, and leaves every other set unchanged.
- R3: When `enter_irq` is high at an edge, `prv_set` takes the old `cur_set`, and `cur_set` takes the map field of `irq_level`. The field for level L is `level_map[L*SET_W +: SET_W]`. A field equal to the current set leaves the bank unchanged.
- R4: When `enter_exc` is high and `enter_irq` is low at an edge, `prv_set` takes the old `cur_set`, and `cur_set` is unchanged.
- R5: When `eret_req` is high and neither entry input is high at an edge, `cur_set` takes `prv_set`, and `prv_set` keeps its value. Priority is `enter_irq` over `enter_exc` over `eret_req`. With none of the three high, both set fields hold.
- R6: `prv_rd_data` returns register `prv_rd_idx` of the set named by `prv_set`.
- R7: A write with `prv_wr_en` high updates register `prv_wr_idx` of the set named by `prv_set` at the next edge.
- R8: Register index 0 reads as zero on every port and in every set. Writes to index 0 through either write port are ignored.
- R9: A read port shows same-cycle write data only when that write targets the same set and the same nonzero register as the read. In any other case the port shows the stored value.
- R10: A pipeline or previous-set write made in the same cycle as a set switch lands in the set that was addressed before the switch.
- R11: When both write ports target the same set and register in one cycle, the pipeline write's data is stored, and the same-cycle bypass also shows the pipeline write's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| rd_a_idx | input | IDX_W | Read port A register index (current set) |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | IDX_W | Read port B register index (current set) |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Pipeline write enable (current set) |
| wr_idx | input | IDX_W | Pipeline write register index |
| wr_data | input | DATA_W | Pipeline write data |
| prv_rd_idx | input | IDX_W | Previous-set read index |
| prv_rd_data | output | DATA_W | Previous-set read data |
| prv_wr_en | input | 1 | Previous-set write enable |
| prv_wr_idx | input | IDX_W | Previous-set write index |
| prv_wr_data | input | DATA_W | Previous-set write data |
| enter_irq | input | 1 | Interrupt entry: switch to the mapped set |
| irq_level | input | LVL_W | Priority level of the entry |
| enter_exc | input | 1 | Exception entry: record previous set, keep bank |
| eret_req | input | 1 | Handler return: restore previous set |
| level_map | input | NUM_LEVELS*SET_W | Set number assigned to each level |
| cur_set | output | SET_W | Current set number |
| prv_set | output | SET_W | Previous set number |

## Verification
Every set is filled through interrupt entries with a value that depends on both the set and the register, such as set*4096 + reg*17 + 257. Each set is then swept on all three read ports, with port B walking the indices in reverse. A port that reads the wrong bank, or swaps the index bits, therefore returns a value different from the expected one. Entry, exception and return events are then applied in sequences that make the current and previous sets differ, and again in sequences that make them equal. This separates reads and writes that follow the previous field from those that follow the current one. Same-cycle tests cover a write that hits the same set as a read, a write to another set, two writes that collide, a write at a set switch, and simultaneous control events, so that each bypass and ordering rule is tried where it matters.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
package srf_pkg;

  // Set-switch event for one clock, after priority has been resolved.
  typedef enum logic [1:0] {
    EVT_NONE = 2'd0,
    EVT_IRQ  = 2'd1,
    EVT_EXC  = 2'd2,
    EVT_RET  = 2'd3
  } sw_evt_e;

  // Interrupt entry beats exception entry, which beats return.
  function automatic sw_evt_e pick_evt(input logic irq, input logic exc,
                                       input logic ret);
    if (irq)      return EVT_IRQ;
    else if (exc) return EVT_EXC;
    else if (ret) return EVT_RET;
    else          return EVT_NONE;
  endfunction

endpackage

// File: rtl/srf_bank.sv
`timescale 1ns/1ps
// One register set: two write ports (port A wins a collision), NPORT reads.
module srf_bank #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int NPORT    = 3,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [IDX_W-1:0]  ridx  [NPORT],
  output logic [DATA_W-1:0] rdata [NPORT]
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else begin
      if (wb_en && wb_idx != '0) mem[wb_idx] <= wb_data;
      if (wa_en && wa_idx != '0) mem[wa_idx] <= wa_data;  // later: wins
    end
  end

  for (genvar k = 0; k < NPORT; k++) begin : g_rd
    assign rdata[k] = (ridx[k] == '0) ? '0 : mem[ridx[k]];
  end

endmodule

// File: rtl/srf_setctl.sv
`timescale 1ns/1ps
// Current / previous set control register.
module srf_setctl
  import srf_pkg::*;
#(
  parameter int NUM_SETS   = 4,
  parameter int NUM_LEVELS = 8,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enter_irq,
  input  logic [LVL_W-1:0]            irq_level,
  input  logic                        enter_exc,
  input  logic                        eret_req,
  input  logic [NUM_LEVELS*SET_W-1:0] level_map,
  output logic [SET_W-1:0]            cur_set,
  output logic [SET_W-1:0]            prv_set
);

  sw_evt_e          evt;
  logic [SET_W-1:0] target;

  always_comb begin
    evt    = pick_evt(enter_irq, enter_exc, eret_req);
    target = level_map[irq_level*SET_W +: SET_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_set <= '0;
      prv_set <= '0;
    end else begin
      unique case (evt)
        EVT_IRQ: begin
          prv_set <= cur_set;
          cur_set <= target;
        end
        EVT_EXC: prv_set <= cur_set;
        EVT_RET: cur_set <= prv_set;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/srf_readport.sv
`timescale 1ns/1ps
// Set selection plus same-set, same-register bypass for one read port.
module srf_readport #(
  parameter int NUM_SETS = 4,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [DATA_W-1:0] bank_word [NUM_SETS],
  input  logic [SET_W-1:0]  rset,
  input  logic [IDX_W-1:0]  ridx,
  input  logic              w0_en,
  input  logic [SET_W-1:0]  w0_set,
  input  logic [IDX_W-1:0]  w0_idx,
  input  logic [DATA_W-1:0] w0_data,
  input  logic              w1_en,
  input  logic [SET_W-1:0]  w1_set,
  input  logic [IDX_W-1:0]  w1_idx,
  input  logic [DATA_W-1:0] w1_data,
  output logic [DATA_W-1:0] rdata
);

  logic hit0, hit1;

  always_comb begin
    hit0 = w0_en && (w0_set == rset) && (w0_idx == ridx) && (ridx != '0);
    hit1 = w1_en && (w1_set == rset) && (w1_idx == ridx) && (ridx != '0);
    if (hit0)      rdata = w0_data;
    else if (hit1) rdata = w1_data;
    else           rdata = bank_word[rset];
  end

endmodule

// File: rtl/shadow_regfile.sv
`timescale 1ns/1ps
module shadow_regfile #(
  parameter int NUM_SETS   = 4,
  parameter int NUM_REGS   = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_LEVELS = 8,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_a_idx,
  output logic [DATA_W-1:0]           rd_a_data,
  input  logic [IDX_W-1:0]            rd_b_idx,
  output logic [DATA_W-1:0]           rd_b_data,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [IDX_W-1:0]            prv_rd_idx,
  output logic [DATA_W-1:0]           prv_rd_data,
  input  logic                        prv_wr_en,
  input  logic [IDX_W-1:0]            prv_wr_idx,
  input  logic [DATA_W-1:0]           prv_wr_data,
  input  logic                        enter_irq,
  input  logic [LVL_W-1:0]            irq_level,
  input  logic                        enter_exc,
  input  logic                        eret_req,
  input  logic [NUM_LEVELS*SET_W-1:0] level_map,
  output logic [SET_W-1:0]            cur_set,
  output logic [SET_W-1:0]            prv_set
);

  localparam int NPORT = 3;  // A, B (current set), previous-set read

  srf_setctl #(.NUM_SETS(NUM_SETS), .NUM_LEVELS(NUM_LEVELS)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .enter_irq(enter_irq), .irq_level(irq_level),
    .enter_exc(enter_exc), .eret_req(eret_req),
    .level_map(level_map),
    .cur_set(cur_set), .prv_set(prv_set)
  );

  logic [IDX_W-1:0]  port_idx  [NPORT];
  logic [SET_W-1:0]  port_set  [NPORT];
  logic [DATA_W-1:0] port_out  [NPORT];
  logic [DATA_W-1:0] bank_rd   [NUM_SETS][NPORT];
  logic [DATA_W-1:0] port_word [NPORT][NUM_SETS];

  always_comb begin
    port_idx[0] = rd_a_idx;   port_set[0] = cur_set;
    port_idx[1] = rd_b_idx;   port_set[1] = cur_set;
    port_idx[2] = prv_rd_idx; port_set[2] = prv_set;
  end

  // Write enables are decoded from the set fields before the edge, so a
  // write issued with a switch lands in the old set.
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    srf_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NPORT(NPORT)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wa_en(wr_en && (cur_set == SET_W'(s))),
      .wa_idx(wr_idx), .wa_data(wr_data),
      .wb_en(prv_wr_en && (prv_set == SET_W'(s))),
      .wb_idx(prv_wr_idx), .wb_data(prv_wr_data),
      .ridx(port_idx), .rdata(bank_rd[s])
    );
    for (genvar k = 0; k < NPORT; k++) begin : g_tr
      assign port_word[k][s] = bank_rd[s][k];
    end
  end

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    srf_readport #(.NUM_SETS(NUM_SETS), .NUM_REGS(NUM_REGS),
                   .DATA_W(DATA_W)) u_rp (
      .bank_word(port_word[k]),
      .rset(port_set[k]), .ridx(port_idx[k]),
      .w0_en(wr_en), .w0_set(cur_set), .w0_idx(wr_idx), .w0_data(wr_data),
      .w1_en(prv_wr_en), .w1_set(prv_set), .w1_idx(prv_wr_idx),
      .w1_data(prv_wr_data),
      .rdata(port_out[k])
    );
  end

  assign rd_a_data   = port_out[0];
  assign rd_b_data   = port_out[1];
  assign prv_rd_data = port_out[2];

endmodule

// File: rtl/srf_checker.sv
`timescale 1ns/1ps
module srf_checker #(
  parameter int NUM_SETS   = 4,
  parameter int NUM_REGS   = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_LEVELS = 8,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [IDX_W-1:0]            rd_a_idx,
  input logic [DATA_W-1:0]           rd_a_data,
  input logic [IDX_W-1:0]            prv_rd_idx,
  input logic [DATA_W-1:0]           prv_rd_data,
  input logic                        enter_irq,
  input logic [LVL_W-1:0]            irq_level,
  input logic                        enter_exc,
  input logic                        eret_req,
  input logic [NUM_LEVELS*SET_W-1:0] level_map,
  input logic [SET_W-1:0]            cur_set,
  input logic [SET_W-1:0]            prv_set
);

  logic [SET_W-1:0] mapped;
  assign mapped = level_map[irq_level*SET_W +: SET_W];

  assert_irq_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enter_irq |=> (cur_set == $past(mapped)) && (prv_set == $past(cur_set)));

  assert_exc_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_exc && !enter_irq) |=>
      (cur_set == $past(cur_set)) && (prv_set == $past(cur_set)));

  assert_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_req && !enter_irq && !enter_exc) |=>
      (cur_set == $past(prv_set)) && $stable(prv_set));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!eret_req && !enter_irq && !enter_exc) |=>
      $stable(cur_set) && $stable(prv_set));

  assert_zero_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0));

  assert_zero_prv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prv_rd_idx == '0) |-> (prv_rd_data == '0));

endmodule

bind shadow_regfile srf_checker #(
  .NUM_SETS(NUM_SETS), .NUM_REGS(NUM_REGS),
  .DATA_W(DATA_W), .NUM_LEVELS(NUM_LEVELS)
) u_chk (.*);

// File: tb/sim_shadow_regfile.sv
`timescale 1ns/1ps
module sim_shadow_regfile;
  localparam int NS = 4, NR = 8, DW = 16, NL = 4;
  localparam int SW = 2, IW = 3, LW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n;
  logic [IW-1:0] rd_a_idx, rd_b_idx, wr_idx, prv_rd_idx, prv_wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data, prv_rd_data, prv_wr_data;
  logic wr_en, prv_wr_en, enter_irq, enter_exc, eret_req;
  logic [LW-1:0] irq_level;
  logic [NL*SW-1:0] level_map;
  logic [SW-1:0] cur_set, prv_set;

  shadow_regfile #(.NUM_SETS(NS), .NUM_REGS(NR), .DATA_W(DW),
                   .NUM_LEVELS(NL)) u0 (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] mem [NS][NR];
  int mcur = 0, mprv = 0;

  function automatic int set_of(int lvl); return NS - 1 - lvl; endfunction
  function automatic logic [DW-1:0] pat(int s, int r);
    return DW'(s * 4096 + r * 17 + 257);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic wr(int idx, logic [DW-1:0] d);
    wr_en = 1; wr_idx = IW'(idx); wr_data = d; tick(); wr_en = 0;
    if (idx != 0) mem[mcur][idx] = d;
  endtask

  task automatic pwr(int idx, logic [DW-1:0] d);
    prv_wr_en = 1; prv_wr_idx = IW'(idx); prv_wr_data = d; tick();
    prv_wr_en = 0;
    if (idx != 0) mem[mprv][idx] = d;
  endtask

  task automatic chk_sets(string tag);
    chk({tag, " cur_set"}, cur_set, mcur);
    chk({tag, " prv_set"}, prv_set, mprv);
  endtask

  task automatic irq(int lvl);
    enter_irq = 1; irq_level = LW'(lvl); tick(); enter_irq = 0;
    mprv = mcur; mcur = set_of(lvl);
    chk_sets("R3");
  endtask

  task automatic exc;
    enter_exc = 1; tick(); enter_exc = 0;
    mprv = mcur; chk_sets("R4");
  endtask

  task automatic ret;
    eret_req = 1; tick(); eret_req = 0;
    mcur = mprv; chk_sets("R5");
  endtask

  // Sweep all three read ports; reg 0 must read zero (R8).
  task automatic verify(string tag);
    for (int r = 0; r < NR; r++) begin
      rd_a_idx = IW'(r); rd_b_idx = IW'(NR - 1 - r); prv_rd_idx = IW'(r);
      #1;
      chk({tag, " R2/R8 port A"}, rd_a_data, mem[mcur][r]);
      chk({tag, " R2/R8 port B"}, rd_b_data, mem[mcur][NR - 1 - r]);
      chk({tag, " R6/R8 prev port"}, prv_rd_data, mem[mprv][r]);
    end
  endtask

  initial begin
    rst_n = 0; wr_en = 0; prv_wr_en = 0; enter_irq = 0; enter_exc = 0;
    eret_req = 0; irq_level = '0; wr_idx = '0; wr_data = '0;
    prv_wr_idx = '0; prv_wr_data = '0; rd_a_idx = '0; rd_b_idx = '0;
    prv_rd_idx = '0;
    for (int l = 0; l < NL; l++) level_map[l*SW +: SW] = SW'(set_of(l));
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < NR; r++) mem[s][r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state
    chk_sets("R1");
    verify("R1");

    // Fill every set through interrupt entries (R3, R2, R8 on reg 0)
    for (int s = 0; s < NS; s++) begin
      irq(NS - 1 - s);
      for (int r = 0; r < NR; r++) wr(r, pat(s, r));
    end
    // Read back every set with the previous set one behind (R2, R6)
    for (int s = 0; s < NS; s++) begin
      irq(NS - 1 - s);
      verify("sweep");
    end

    // Entry / exception / return sequences
    irq(2);            // cur1 prv3
    ret();             // cur3 prv3
    irq(1);            // cur2 prv3
    exc();             // cur2 prv2
    irq(3);            // cur0 prv2
    verify("seq");

    // R7: previous-set write reaches set 2, not set 0
    pwr(5, 16'hBEEF);
    rd_a_idx = 3'd5; prv_rd_idx = 3'd5; #1;
    chk("R7 cur untouched", rd_a_data, pat(0, 5));
    chk("R7 prev written", prv_rd_data, 16'hBEEF);
    ret();             // cur2 prv2
    rd_a_idx = 3'd5; #1;
    chk("R7 after return", rd_a_data, 16'hBEEF);

    // R9: bypass only on same set and register
    irq(2);            // cur1 prv2
    wr_en = 1; wr_idx = 3'd3; wr_data = 16'h1234;
    prv_wr_en = 1; prv_wr_idx = 3'd4; prv_wr_data = 16'h5555;
    rd_a_idx = 3'd3; rd_b_idx = 3'd4; prv_rd_idx = 3'd4; #1;
    chk("R9 same-set bypass", rd_a_data, 16'h1234);
    chk("R9 no cross-set bypass", rd_b_data, mem[1][4]);
    chk("R9 prev-port bypass", prv_rd_data, 16'h5555);
    prv_rd_idx = 3'd3; #1;
    chk("R9 no bypass into prev set", prv_rd_data, mem[2][3]);
    tick(); wr_en = 0; prv_wr_en = 0;
    mem[1][3] = 16'h1234; mem[2][4] = 16'h5555;
    verify("R9 after");

    // R11: colliding writes in one set
    exc();             // cur1 prv1
    wr_en = 1; wr_idx = 3'd6; wr_data = 16'hAAAA;
    prv_wr_en = 1; prv_wr_idx = 3'd6; prv_wr_data = 16'hBBBB;
    rd_a_idx = 3'd6; #1;
    chk("R11 bypass picks pipeline write", rd_a_data, 16'hAAAA);
    tick(); wr_en = 0; prv_wr_en = 0;
    mem[1][6] = 16'hAAAA;
    rd_a_idx = 3'd6; #1;
    chk("R11 stored pipeline write", rd_a_data, 16'hAAAA);

    // R10: write issued with a switch lands in the old set
    wr_en = 1; wr_idx = 3'd2; wr_data = 16'h7777;
    enter_irq = 1; irq_level = 2'd0;
    tick(); wr_en = 0; enter_irq = 0;
    mem[1][2] = 16'h7777; mprv = mcur; mcur = set_of(0);  // cur3 prv1
    chk_sets("R10");
    rd_a_idx = 3'd2; prv_rd_idx = 3'd2; #1;
    chk("R10 old set written", prv_rd_data, 16'h7777);
    chk("R10 new set untouched", rd_a_data, pat(3, 2));

    // R5: priority among simultaneous events
    enter_irq = 1; irq_level = 2'd1; eret_req = 1;
    tick(); enter_irq = 0; eret_req = 0;
    mprv = mcur; mcur = set_of(1);                        // cur2 prv3
    chk_sets("R5 irq beats return");
    enter_exc = 1; eret_req = 1;
    tick(); enter_exc = 0; eret_req = 0;
    mprv = mcur;                                          // cur2 prv2
    chk_sets("R5 exception beats return");
    enter_irq = 1; irq_level = 2'd3; enter_exc = 1;
    tick(); enter_irq = 0; enter_exc = 0;
    mprv = mcur; mcur = set_of(3);                        // cur0 prv2
    chk_sets("R5 irq beats exception");
    tick();
    chk_sets("R5 idle hold");

    // R8: writes to register 0 ignored on both write ports
    wr(0, 16'hFFFF);
    pwr(0, 16'hFFFF);
    rd_a_idx = '0; prv_rd_idx = '0; #1;
    chk("R8 pipeline zero", rd_a_data, 0);
    chk("R8 prev zero", prv_rd_data, 0);

    // Final sweep of every set
    for (int s = 0; s < NS; s++) begin
      irq(NS - 1 - s);
      verify("final");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule